// File: doc/BRIEF.md
# DMA Burst and Single Request Splitter

This block turns one indirect transfer of a known byte count into a sequence of handshake requests toward an external DMA engine. When a transfer is started, the block works out how many whole bursts fit into the byte count. It then works out how many single-sized requests cover what is left after those bursts. It issues every burst request first and then every single request. Only one request is open at any time, and each stays raised until the engine acknowledges it.

A request is raised only when the data buffer reports that it can take or give the next piece and the DMA path is enabled for an indirect transfer. A design places one instance on the read direction and one on the write direction. Burst and single sizes are given as base-two logarithms. The byte count and both sizes are captured when the transfer starts, so later changes on those inputs have no effect on a running transfer. A one-cycle done pulse follows the final acknowledge.

Top module: `dma_req_splitter`

## Requirements
- R1: The number of burst requests equals the byte count shifted right by the burst log2 code, where code n means 2^n bytes and legal codes run from 2 (4 bytes) to 15 (32768 bytes).
- R2: The number of single requests equals (byte count modulo burst size) shifted right by the single log2 code. Any leftover smaller than one single is not requested.
- R3: Within one transfer, no burst request is raised after any single request.
- R4: At most one of burst_req and single_req is high at any time. A raised request stays high until ack is sampled high, and it drops on the edge that samples ack. An ack while no request is raised has no effect.
- R5: A request rises only on an edge where xfer_en and buf_ready were both sampled high. The first request can rise at the earliest on the second edge after the edge that takes start.
- R6: done is high for exactly one cycle, beginning on the edge that samples the last ack. At all other times done is low.
- R7: A transfer that yields zero bursts and zero singles raises no request, and done pulses on the edge that takes start.
- R8: While a transfer is running, changes on start, total_bytes, burst_log2 and single_log2 do not change the requests that are issued.
- R9: start is taken only while the block is idle and xfer_en is high.
- R10: While rst is high, and on the first cycle after it, burst_req, single_req and done are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin a transfer (one-cycle pulse) |
| xfer_en | input | 1 | DMA path enabled and transfer is indirect |
| total_bytes | input | CNT_W | Transfer length in bytes |
| burst_log2 | input | 4 | log2 of burst size in bytes |
| single_log2 | input | 4 | log2 of single size in bytes |
| buf_ready | input | 1 | Buffer watermark permits the next request |
| ack | input | 1 | Engine acknowledge of the open request |
| burst_req | output | 1 | Burst request, held until ack |
| single_req | output | 1 | Single request, held until ack |
| done | output | 1 | One-cycle completion pulse |

## Verification
A request is due one edge after the block is in its issue state with xfer_en and buf_ready sampled high, which means two edges after the start edge. The next request is due one edge after the ack edge. done is due on the same edge that samples the final ack, or on the start edge itself when both counts are zero. The bench drives inputs on falling edges and reads outputs on the falling edge right after the rising edge where each result is due. It checks the request count and the done pulse in exactly those half-cycles and checks that done is low again one cycle later.

// File: rtl/dma_split_pkg.sv
package dma_split_pkg;
  localparam int LOG_W   = 4;
  localparam int MIN_LOG = 2;
  localparam int MAX_LOG = 15;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_ISSUE = 2'd1,
    ST_WAIT  = 2'd2
  } split_state_t;
endpackage

// File: rtl/dma_split_calc.sv
module dma_split_calc
  import dma_split_pkg::*;
#(
  parameter int CNT_W = 20
) (
  input  logic [CNT_W-1:0] total_bytes,
  input  logic [LOG_W-1:0] burst_log2,
  input  logic [LOG_W-1:0] single_log2,
  output logic [CNT_W-1:0] n_burst,
  output logic [CNT_W-1:0] n_single
);
  localparam logic [LOG_W-1:0] LO = LOG_W'(MIN_LOG);
  localparam logic [LOG_W-1:0] HI = LOG_W'(MAX_LOG);
  localparam logic [CNT_W-1:0] ONE = {{(CNT_W-1){1'b0}}, 1'b1};

  logic [LOG_W-1:0] b_eff, s_eff;
  logic [CNT_W-1:0] b_mask, rem;

  // Out-of-range codes are clamped to the legal 4..32768 byte window.
  always_comb begin
    b_eff = (burst_log2 < LO) ? LO : ((burst_log2 > HI) ? HI : burst_log2);
    s_eff = (single_log2 < LO) ? LO : ((single_log2 > HI) ? HI : single_log2);
    b_mask   = (ONE << b_eff) - ONE;
    rem      = total_bytes & b_mask;
    n_burst  = total_bytes >> b_eff;
    n_single = rem >> s_eff;
  end
endmodule

// File: rtl/dma_req_fsm.sv
module dma_req_fsm
  import dma_split_pkg::*;
#(
  parameter int CNT_W = 20
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start,
  input  logic             xfer_en,
  input  logic             buf_ready,
  input  logic             ack,
  input  logic [CNT_W-1:0] n_burst,
  input  logic [CNT_W-1:0] n_single,
  output logic             burst_req,
  output logic             single_req,
  output logic             done
);
  localparam logic [CNT_W-1:0] ONE = {{(CNT_W-1){1'b0}}, 1'b1};

  split_state_t     state;
  logic [CNT_W-1:0] bursts_left, singles_left;
  logic             last_one;

  always_comb begin
    if (burst_req) last_one = (bursts_left == ONE) && (singles_left == '0);
    else           last_one = (singles_left == ONE) && (bursts_left == '0);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state        <= ST_IDLE;
      bursts_left  <= '0;
      singles_left <= '0;
      burst_req    <= 1'b0;
      single_req   <= 1'b0;
      done         <= 1'b0;
    end else begin
      done <= 1'b0;
      unique case (state)
        ST_IDLE: begin
          if (start && xfer_en) begin
            if (n_burst == '0 && n_single == '0) begin
              done <= 1'b1;
            end else begin
              bursts_left  <= n_burst;
              singles_left <= n_single;
              state        <= ST_ISSUE;
            end
          end
        end
        ST_ISSUE: begin
          if (xfer_en && buf_ready) begin
            if (bursts_left != '0) burst_req  <= 1'b1;
            else                   single_req <= 1'b1;
            state <= ST_WAIT;
          end
        end
        ST_WAIT: begin
          if (ack) begin
            burst_req  <= 1'b0;
            single_req <= 1'b0;
            if (burst_req) bursts_left  <= bursts_left - ONE;
            else           singles_left <= singles_left - ONE;
            if (last_one) begin
              done  <= 1'b1;
              state <= ST_IDLE;
            end else begin
              state <= ST_ISSUE;
            end
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/dma_req_splitter.sv
module dma_req_splitter
  import dma_split_pkg::*;
#(
  parameter int CNT_W = 20
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start,
  input  logic             xfer_en,
  input  logic [CNT_W-1:0] total_bytes,
  input  logic [LOG_W-1:0] burst_log2,
  input  logic [LOG_W-1:0] single_log2,
  input  logic             buf_ready,
  input  logic             ack,
  output logic             burst_req,
  output logic             single_req,
  output logic             done
);
  logic [CNT_W-1:0] n_burst, n_single;

  dma_split_calc #(.CNT_W(CNT_W)) u_calc (
    .total_bytes (total_bytes),
    .burst_log2  (burst_log2),
    .single_log2 (single_log2),
    .n_burst     (n_burst),
    .n_single    (n_single)
  );

  dma_req_fsm #(.CNT_W(CNT_W)) u_fsm (
    .clk        (clk),
    .rst        (rst),
    .start      (start),
    .xfer_en    (xfer_en),
    .buf_ready  (buf_ready),
    .ack        (ack),
    .n_burst    (n_burst),
    .n_single   (n_single),
    .burst_req  (burst_req),
    .single_req (single_req),
    .done       (done)
  );
endmodule

// File: rtl/dma_req_splitter_chk.sv
module dma_req_splitter_chk (
  input logic clk,
  input logic rst,
  input logic xfer_en,
  input logic buf_ready,
  input logic ack,
  input logic burst_req,
  input logic single_req,
  input logic done
);
  logic single_seen;

  always_ff @(posedge clk) begin
    if (rst)             single_seen <= 1'b0;
    else if (done)       single_seen <= 1'b0;
    else if (single_req) single_seen <= 1'b1;
  end

  assert_one_req_R4: assert property (@(posedge clk) disable iff (rst)
    $onehot0({burst_req, single_req}));

  assert_burst_held_R4: assert property (@(posedge clk) disable iff (rst)
    (burst_req && !ack) |=> burst_req);

  assert_single_held_R4: assert property (@(posedge clk) disable iff (rst)
    (single_req && !ack) |=> single_req);

  assert_burst_gate_R5: assert property (@(posedge clk) disable iff (rst)
    $rose(burst_req) |-> $past(buf_ready && xfer_en));

  assert_single_gate_R5: assert property (@(posedge clk) disable iff (rst)
    $rose(single_req) |-> $past(buf_ready && xfer_en));

  assert_done_pulse_R6: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  assert_done_quiet_R6: assert property (@(posedge clk) disable iff (rst)
    done |-> !(burst_req || single_req));

  assert_order_R3: assert property (@(posedge clk) disable iff (rst)
    burst_req |-> !single_seen);
endmodule

bind dma_req_splitter dma_req_splitter_chk u_chk (.*);

// File: tb/test_dma_req_splitter.sv
module test_dma_req_splitter;
  localparam int CNT_W = 20;
  localparam int NV = 10;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic start = 1'b0, xfer_en = 1'b0, buf_ready = 1'b0, ack = 1'b0;
  logic [CNT_W-1:0] total_bytes = '0;
  logic [3:0] burst_log2 = 4'd2, single_log2 = 4'd2;
  logic burst_req, single_req, done;

  int total = 0;
  int bad = 0;

  always #5 clk = ~clk;

  dma_req_splitter #(.CNT_W(CNT_W)) i_dma_req_splitter (
    .clk(clk), .rst(rst), .start(start), .xfer_en(xfer_en),
    .total_bytes(total_bytes), .burst_log2(burst_log2), .single_log2(single_log2),
    .buf_ready(buf_ready), .ack(ack),
    .burst_req(burst_req), .single_req(single_req), .done(done)
  );

  // columns: bytes, burst code, single code, expected bursts, expected singles
  localparam int V_TOT[NV] = '{64, 100, 28, 12, 200, 60, 32, 4, 65536, 36};
  localparam int V_BL [NV] = '{4, 5, 4, 5, 6, 5, 2, 15, 15, 3};
  localparam int V_SL [NV] = '{2, 2, 2, 2, 3, 4, 2, 2, 2, 3};
  localparam int V_EB [NV] = '{4, 3, 1, 0, 3, 1, 8, 0, 2, 4};
  localparam int V_ES [NV] = '{0, 1, 3, 3, 1, 1, 0, 1, 0, 0};

  task automatic check(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic run_xfer(input int tot, input int bl, input int sl,
                          input int eb, input int es, input int dly, input bit disturb);
    int nb = 0, ns = 0;
    bit seen_s = 0, order_bad = 0, held_bad = 0, both = 0, got_done = 0, done_ok = 0;
    @(negedge clk);
    total_bytes = CNT_W'(tot); burst_log2 = 4'(bl); single_log2 = 4'(sl);
    xfer_en = 1; buf_ready = 1; start = 1;
    @(negedge clk);
    start = 0;
    for (int c = 0; c < 4000 && !got_done; c++) begin
      @(negedge clk);
      if (done) got_done = 1;
      else if (burst_req || single_req) begin
        if (burst_req && single_req) both = 1;
        if (burst_req) begin nb++; if (seen_s) order_bad = 1; end
        else begin ns++; seen_s = 1; end
        if (disturb) begin
          total_bytes = '0; burst_log2 = 4'd15; single_log2 = 4'd15; start = 1;
        end
        for (int d = 0; d < dly; d++) begin
          @(negedge clk);
          if (!(burst_req || single_req)) held_bad = 1;
        end
        ack = 1; start = 0;
        @(negedge clk);
        ack = 0;
        if (burst_req || single_req) held_bad = 1;
        if (done) begin got_done = 1; done_ok = 1; end
      end
    end
    check(nb == eb, "R1 burst count", nb, eb);
    check(ns == es, "R2 single count", ns, es);
    check(!order_bad, "R3 burst after single", order_bad, 0);
    check(!held_bad && !both, "R4 hold/one request", held_bad, 0);
    check(done_ok, "R6 done right after last ack", done_ok, 1);
    @(negedge clk);
    check(!done, "R6 done one cycle", done, 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    bad++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check(!burst_req && !single_req && !done, "R10 reset outputs", {burst_req, single_req, done}, 0);
    rst = 0;
    @(negedge clk);
    check(!burst_req && !single_req && !done, "R10 after reset", {burst_req, single_req, done}, 0);

    for (int v = 0; v < NV; v++)
      run_xfer(V_TOT[v], V_BL[v], V_SL[v], V_EB[v], V_ES[v], v % 3, 1'b0);

    // R8: config and start disturbed during the run (64 bytes, 16 B bursts)
    run_xfer(64, 4, 2, 4, 0, 1, 1'b1);

    // R7: zero-length transfer
    @(negedge clk);
    total_bytes = '0; xfer_en = 1; buf_ready = 1; start = 1;
    @(negedge clk);
    start = 0;
    check(done && !burst_req && !single_req, "R7 zero total done", done, 1);
    @(negedge clk);
    check(!done && !burst_req && !single_req, "R7 no request", {done, burst_req, single_req}, 0);

    // R9: start ignored with xfer_en low
    total_bytes = 20'd16; burst_log2 = 4'd2; xfer_en = 0; start = 1;
    @(negedge clk);
    start = 0;
    xfer_en = 1;
    repeat (4) @(negedge clk);
    check(!burst_req && !single_req && !done, "R9 start with en low", {burst_req, single_req, done}, 0);

    // R5 + R4: buffer not ready, stray ack ignored (8 bytes, one 8 B burst)
    total_bytes = 20'd8; burst_log2 = 4'd3; single_log2 = 4'd2; buf_ready = 0; start = 1;
    @(negedge clk);
    start = 0; ack = 1;
    @(negedge clk);
    ack = 0;
    repeat (3) @(negedge clk);
    check(!burst_req && !single_req && !done, "R5 held off by buf_ready", burst_req, 0);
    buf_ready = 1;
    @(negedge clk);
    check(burst_req, "R4 stray ack ignored, burst due", burst_req, 1);
    ack = 1;
    @(negedge clk);
    ack = 0;
    check(done && !burst_req, "R6 done after single burst", done, 1);

    // R5: xfer_en low pauses issuing (8 bytes, two 4 B bursts)
    @(negedge clk);
    total_bytes = 20'd8; burst_log2 = 4'd2; start = 1;
    @(negedge clk);
    start = 0;
    @(negedge clk);
    check(burst_req, "R5 first request two edges after start", burst_req, 1);
    ack = 1; xfer_en = 0;
    @(negedge clk);
    ack = 0;
    repeat (4) @(negedge clk);
    check(!burst_req && !done, "R5 paused by xfer_en", burst_req, 0);
    xfer_en = 1;
    @(negedge clk);
    check(burst_req, "R5 resumes with xfer_en", burst_req, 1);
    ack = 1;
    @(negedge clk);
    ack = 0;
    check(done, "R6 done after second burst", done, 1);
    @(negedge clk);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule